// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the command wire of an SD/MMC host. When the host strobes a command, it serialises a 48-bit frame onto the CMD line: a start bit, a transmission bit, the 6-bit index, the 32-bit argument, a CRC7 and an end bit. If the host asked for a response, it then waits through a short turnaround and captures a short (32-bit) or long (127-bit) reply. A short reply is checked for its CRC and for its echoed index. After the exchange the line stays released for a few card clocks before the engine goes idle. An optional burst of 80 high clocks can be inserted ahead of the next command, and the engine can also issue a stop command of its own.

Every step advances only on a card-clock enable, so the engine runs from the system clock at any card rate. The state is kept as a 19-bit one-hot vector and reported through a 4-bit code. Three hold states, used while other logic owns the line, read back as idle. The index of the most recent response is retained, whether the host or the engine issued the command.

Top module: `sd_cmd_engine`

## Requirements
- R1: A command frame goes out MSB first, one bit per state step, as 0, 1, index[5:0], argument[31:0], CRC7, 1. The CRC7 uses polynomial x^7+x^3+1 and a zero seed, and covers the first 40 bits. The index-0, argument-0 frame is 48'h400000000095.
- R2: Apart from leaving idle or a hold state, the state moves and the CMD line is sampled or shifted only on a clock edge where `cclk_en` is 1. With `cclk_en` at 0 the current bit and state code are held.
- R3: `cmd_oe` is 1 only in the init state and the five command-transmit states, and is 0 everywhere else. During init `cmd_o` is 1.
- R4: After an `init_req` pulse, the next accepted command first spends 80 enable ticks in state code 1 and then sends its frame. Later commands start with no init.
- R5: `state_code` reports the one-hot state as 0 idle, 1 init, 2 start bit, 3 transmission bit, 4 index and argument, 5 CRC7, 6 end bit, 7 response start search, 8 interrupt response, 9 response transmission bit, 10 response index, 11 response payload, 12 response CRC7, 13 response end bit, 14 NCC wait, 15 turnaround. The three hold states report 0.
- R6: After a command end bit with no response expected, or after a response end bit, the line is released in state 14 for 8 ticks, and then the engine is idle.
- R7: A short response carries 0, tx bit, index[5:0], payload[31:0], CRC7 and 1. When its end bit is sampled, `resp_done` pulses for one clock and `resp` becomes the payload zero-extended. `crc_err` is set if the CRC7 over the first 40 bits differs from the received CRC7. `idx_err` is set if the received index differs from the command index.
- R8: A long response carries 0, tx bit, a 6-bit field, a 127-bit payload and 1. `resp` takes all 127 bits, and neither `crc_err` nor `idx_err` is set.
- R9: When a response is expected, a low bit is looked for only after a 2-tick turnaround. If none is sampled by the 64th tick after the command end bit, `timeout` goes to 1 on that tick and the engine goes straight to idle. `timeout`, `crc_err` and `idx_err` clear when a new command is accepted.
- R10: `last_idx` resets to 0 and takes the received 6-bit index field of every completed response, including the response to an engine-issued stop.
- R11: `stop_req` in idle sends index 12 with argument 0 and a short response expected. It takes priority over `start` in the same cycle.
- R12: `start` and `stop_req` are ignored unless the state is idle. In idle with neither strobe asserted, `hold_mode` values 1, 2 and 3 enter the wait-CCS, send-CCSD and boot hold states. The engine stays in that state while `hold_mode` keeps that value, and returns to idle when it changes.
- R13: After reset, `state_code` is 0, `cmd_oe` is 0, `cmd_o` is 1, and every flag and `last_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cclk_en | input | 1 | Card-clock tick enable |
| init_req | input | 1 | Request init clocks before the next command |
| start | input | 1 | Launch a host command |
| stop_req | input | 1 | Launch an engine-issued stop command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_exp | input | 1 | A response is expected |
| resp_long | input | 1 | The expected response is long |
| hold_mode | input | 2 | Hold state select (0 none) |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_i | input | 1 | CMD line sampled value |
| resp_done | output | 1 | One-clock pulse when a response completes |
| crc_err | output | 1 | Short response CRC7 mismatch |
| idx_err | output | 1 | Short response index mismatch |
| timeout | output | 1 | No response start bit in the window |
| resp | output | 127 | Captured response payload |
| last_idx | output | 6 | Index field of the latest response |
| state_code | output | 4 | Reported state code |

## Verification
A one-hot vector with a stray or missing bit would show up at once as an unexpected `state_code` or an unexpected `cmd_oe`. A counter that is off by one would shift every later frame bit by one position, so the very next bit comparison on `cmd_o` would fail. It would also move the `resp_done` pulse, the `timeout` tick or the return to idle by a cycle, and the bench samples each of these on the exact clock. A receive path that went wrong would show within the same response as a bad `resp`, `crc_err` or `idx_err`, or as a wrong `last_idx`.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int INIT_CLKS = 80,
  parameter int NCC_CLKS  = 8,
  parameter int TURN_CLKS = 2,
  parameter int RESP_TMO  = 64,
  parameter int STOP_CMD  = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cclk_en,
  input  logic         init_req,
  input  logic         start,
  input  logic         stop_req,
  input  logic [5:0]   cmd_idx,
  input  logic [31:0]  cmd_arg,
  input  logic         resp_exp,
  input  logic         resp_long,
  input  logic [1:0]   hold_mode,
  output logic         cmd_o,
  output logic         cmd_oe,
  input  logic         cmd_i,
  output logic         resp_done,
  output logic         crc_err,
  output logic         idx_err,
  output logic         timeout,
  output logic [126:0] resp,
  output logic [5:0]   last_idx,
  output logic [3:0]   state_code
);
  localparam int NS = 19;
  localparam int S_IDLE = 0, S_INIT = 1, S_TSTART = 2, S_TTX = 3, S_TBODY = 4,
                 S_TCRC = 5, S_TEND = 6, S_RSTART = 7, S_RIRQ = 8, S_RTX = 9,
                 S_RIDX = 10, S_RDATA = 11, S_RCRC = 12, S_REND = 13, S_NCC = 14,
                 S_TURN = 15, S_WCCS = 16, S_SCCSD = 17, S_BOOT = 18;
  localparam int CMAX = (INIT_CLKS > RESP_TMO) ? ((INIT_CLKS > 128) ? INIT_CLKS : 128)
                                               : ((RESP_TMO > 128) ? RESP_TMO : 128);
  localparam int CW = $clog2(CMAX) + 1;

  logic [NS-1:0] st, nst;
  logic [CW-1:0] cnt;
  logic [47:0]   frame;
  logic          init_pend, exp_q, long_q, txb;
  logic [5:0]    cidx, ridx;
  logic [126:0]  rsh;
  logic [6:0]    rcrc;

  wire accept  = st[S_IDLE] & (start | stop_req);
  wire holding = st[S_WCCS] | st[S_SCCSD] | st[S_BOOT];
  wire tick    = cclk_en;
  int  hold_sel;
  assign hold_sel = S_WCCS + int'(hold_mode) - 1;

  function automatic logic [NS-1:0] oh(input int i);
    logic [NS-1:0] r;
    r = '0;
    r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int k = 39; k >= 0; k--) begin
      fb = d[k] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_frame(input logic [5:0] i, input logic [31:0] a);
    return {2'b01, i, a, crc7({2'b01, i, a}), 1'b1};
  endfunction

  always_comb begin
    nst = st;
    if (st[S_IDLE]) begin
      if (accept)                  nst = oh(init_pend ? S_INIT : S_TSTART);
      else if (hold_mode != 2'd0)  nst = oh(hold_sel);
    end else if (holding) begin
      if (!st[hold_sel])           nst = oh(S_IDLE);
    end else if (tick) begin
      case (1'b1)
        st[S_INIT]:   if (cnt == CW'(INIT_CLKS - 1)) nst = oh(S_TSTART);
        st[S_TSTART]: nst = oh(S_TTX);
        st[S_TTX]:    nst = oh(S_TBODY);
        st[S_TBODY]:  if (cnt == CW'(37)) nst = oh(S_TCRC);
        st[S_TCRC]:   if (cnt == CW'(6)) nst = oh(S_TEND);
        st[S_TEND]:   nst = oh(exp_q ? S_TURN : S_NCC);
        st[S_TURN]:   if (cnt == CW'(TURN_CLKS - 1)) nst = oh(S_RSTART);
        st[S_RSTART]: if (!cmd_i) nst = oh(S_RTX);
                      else if (cnt == CW'(RESP_TMO - 1)) nst = oh(S_IDLE);
        st[S_RTX]:    nst = oh(S_RIDX);
        st[S_RIDX]:   if (cnt == CW'(5)) nst = oh(S_RDATA);
        st[S_RDATA]:  if (cnt == (long_q ? CW'(126) : CW'(31)))
                        nst = oh(long_q ? S_REND : S_RCRC);
        st[S_RCRC]:   if (cnt == CW'(6)) nst = oh(S_REND);
        st[S_REND]:   nst = oh(S_NCC);
        st[S_NCC]:    if (cnt == CW'(NCC_CLKS - 1)) nst = oh(S_IDLE);
        default:      nst = oh(S_IDLE);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= oh(S_IDLE);
      cnt <= '0;
      frame <= '1;
      init_pend <= 1'b0;
      exp_q <= 1'b0;
      long_q <= 1'b0;
      cidx <= '0;
      txb <= 1'b0;
      ridx <= '0;
      rsh <= '0;
      rcrc <= '0;
      resp_done <= 1'b0;
      crc_err <= 1'b0;
      idx_err <= 1'b0;
      timeout <= 1'b0;
      resp <= '0;
      last_idx <= '0;
    end else begin
      st <= nst;
      resp_done <= 1'b0;
      if (nst != st && !(st[S_TURN] && nst[S_RSTART])) cnt <= '0;
      else if (tick && !st[S_IDLE]) cnt <= cnt + 1'b1;

      if (init_req) init_pend <= 1'b1;
      if (accept) begin
        if (init_pend) init_pend <= 1'b0;
        frame   <= stop_req ? mk_frame(6'(STOP_CMD), 32'h0) : mk_frame(cmd_idx, cmd_arg);
        cidx    <= stop_req ? 6'(STOP_CMD) : cmd_idx;
        exp_q   <= stop_req | resp_exp;
        long_q  <= !stop_req & resp_long;
        crc_err <= 1'b0;
        idx_err <= 1'b0;
        timeout <= 1'b0;
      end

      if (tick) begin
        if (|st[S_TEND:S_TSTART]) frame <= {frame[46:0], 1'b1};
        if (st[S_RTX])   txb  <= cmd_i;
        if (st[S_RIDX])  ridx <= {ridx[4:0], cmd_i};
        if (st[S_RDATA]) rsh  <= {rsh[125:0], cmd_i};
        if (st[S_RCRC])  rcrc <= {rcrc[5:0], cmd_i};
        if (st[S_RSTART] && cmd_i && cnt == CW'(RESP_TMO - 1)) timeout <= 1'b1;
        if (st[S_REND]) begin
          resp_done <= 1'b1;
          last_idx  <= ridx;
          resp      <= long_q ? rsh : {95'b0, rsh[31:0]};
          crc_err   <= !long_q && (crc7({1'b0, txb, ridx, rsh[31:0]}) != rcrc);
          idx_err   <= !long_q && (ridx != cidx);
        end
      end
    end
  end

  assign cmd_oe = |st[S_TEND:S_INIT];
  assign cmd_o  = st[S_INIT] | frame[47];

  always_comb begin
    state_code = 4'd0;
    for (int i = 0; i < 16; i++)
      if (st[i]) state_code = state_code | 4'(i);
  end

  // R5
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(st) == 1);

  // R5
  hold_reads_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[S_WCCS] | st[S_SCCSD] | st[S_BOOT]) |-> state_code == 4'd0);

  // R3
  oe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (state_code >= 4'd1 && state_code <= 4'd6));

  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> st[S_IDLE]);

  // R7
  done_in_ncc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> st[S_NCC]);

  // R2
  ncc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[S_NCC] && !cclk_en) |=> st[S_NCC]);
endmodule

// File: tb/sd_cmd_engine_bench.sv
`timescale 1ns/1ps
module sd_cmd_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, cclk_en = 1'b1, init_req = 1'b0;
  logic start = 1'b0, stop_req = 1'b0, resp_exp = 1'b0, resp_long = 1'b0, cmd_i = 1'b1;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0] hold_mode = '0;
  logic cmd_o, cmd_oe, resp_done, crc_err, idx_err, timeout;
  logic [126:0] resp;
  logic [5:0] last_idx;
  logic [3:0] state_code;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (.*);

  // idx, arg, resp_exp, resp_long, resp idx, resp data, bad crc
  localparam logic [78:0] VEC [0:5] = '{
    {6'd0,  32'h0000_0000, 1'b0, 1'b0, 6'd0,  32'h0000_0000, 1'b0},
    {6'd8,  32'h0000_01AA, 1'b1, 1'b0, 6'd8,  32'h0000_01AA, 1'b0},
    {6'd17, 32'h1234_5678, 1'b1, 1'b0, 6'd17, 32'hDEAD_BEEF, 1'b1},
    {6'd55, 32'h0000_0000, 1'b1, 1'b0, 6'd54, 32'h0000_0120, 1'b0},
    {6'd2,  32'h0000_0000, 1'b1, 1'b1, 6'h3f, 32'hA5A5_F00F, 1'b0},
    {6'd63, 32'hFFFF_FFFF, 1'b0, 1'b0, 6'd0,  32'h0000_0000, 1'b0}
  };

  function automatic logic [6:0] bcrc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int k = 39; k >= 0; k--) begin
      logic fb = d[k] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] bframe(input logic [5:0] i, input logic [31:0] a);
    return {2'b01, i, a, bcrc({2'b01, i, a}), 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] i, input logic [31:0] a, input logic re, input logic rl,
                      input logic st_v, input logic sp_v);
    @(negedge clk);
    cmd_idx = i; cmd_arg = a; resp_exp = re; resp_long = rl; start = st_v; stop_req = sp_v;
    @(negedge clk);
    start = 1'b0; stop_req = 1'b0;
  endtask

  task automatic grab(output logic [47:0] f);
    f[47] = cmd_o;
    for (int k = 46; k >= 0; k--) begin
      @(negedge clk);
      f[k] = cmd_o;
    end
  endtask

  task automatic reply(input logic [5:0] ri, input logic [126:0] d, input logic lng, input logic bad);
    logic [135:0] v;
    int n;
    if (lng) begin
      v = {2'b00, ri, d, 1'b1};
      n = 136;
    end else begin
      v = {2'b00, ri, d[31:0], bcrc({2'b00, ri, d[31:0]}) ^ {6'b0, bad}, 1'b1, 88'b0};
      n = 48;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_i = v[135-k];
    end
    @(negedge clk);
    cmd_i = 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && state_code != 4'd0; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [47:0] f;
    logic [126:0] d;
    int bad;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 code", state_code, 0);
    chk("R13 oe/o", {cmd_oe, cmd_o}, 2'b01);
    chk("R13 flags", {resp_done, crc_err, idx_err, timeout, last_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [5:0] ci, ri;
      logic [31:0] ca, rd;
      logic re, rl, bc;
      {ci, ca, re, rl, ri, rd, bc} = VEC[v];
      send(ci, ca, re, rl, 1'b1, 1'b0);
      grab(f);
      chk("R1 frame", f, bframe(ci, ca));
      if (v == 0) chk("R1 cmd0 literal", f, 48'h400000000095);
      if (re) begin
        d = rl ? {rd[30:0], rd, rd, rd} : {95'b0, rd};
        reply(ri, d, rl, bc);
        chk(rl ? "R8 done" : "R7 done", resp_done, 1);
        chk(rl ? "R8 resp" : "R7 resp", resp, d);
        chk(rl ? "R8 errs" : "R7 errs", {crc_err, idx_err}, {!rl && bc, !rl && (ri != ci)});
        chk("R10 last_idx", last_idx, ri);
        chk("R6 ncc after resp", state_code, 14);
        @(negedge clk);
        chk("R7 done one clock", resp_done, 0);
        repeat (7) @(negedge clk);
      end else begin
        @(negedge clk);
        chk("R6 ncc code", {state_code, cmd_oe}, {4'd14, 1'b0});
        repeat (8) @(negedge clk);
      end
      chk("R6 idle after ncc", state_code, 0);
    end

    // R9 timeout
    send(6'd13, 32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    grab(f);
    repeat (64) @(negedge clk);
    chk("R9 before window end", {timeout, state_code}, {1'b0, 4'd7});
    @(negedge clk);
    chk("R9 timeout idle", {timeout, state_code}, {1'b1, 4'd0});
    send(6'd1, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 cleared on accept", timeout, 0);
    grab(f);
    wait_idle();

    // R4 init sequence
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    send(6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    bad = 0;
    for (int k = 0; k < 80; k++) begin
      if (!(state_code == 4'd1 && cmd_oe && cmd_o)) bad++;
      @(negedge clk);
    end
    chk("R4 init 80 high ticks", bad, 0);
    grab(f);
    chk("R4 frame after init", f, bframe(6'd0, 32'h0));
    wait_idle();
    send(6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 no second init", state_code, 2);
    grab(f);
    wait_idle();

    // R2 stall on enable low
    send(6'd9, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    cclk_en = 1'b0;
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!(state_code == 4'd2 && cmd_o == 1'b0)) bad++;
    end
    chk("R2 hold while disabled", bad, 0);
    cclk_en = 1'b1;
    @(negedge clk);
    chk("R2 advance on tick", {state_code, cmd_o}, {4'd3, 1'b1});
    wait_idle();

    // R11 stop has priority, R10 tracks its response
    send(6'd5, 32'h7777_7777, 1'b0, 1'b0, 1'b1, 1'b1);
    grab(f);
    chk("R11 stop frame", f, bframe(6'd12, 32'h0));
    reply(6'd12, {95'b0, 32'h0000_0900}, 1'b0, 1'b0);
    chk("R11 stop response", {resp_done, crc_err, idx_err}, 3'b100);
    chk("R10 last_idx stop", last_idx, 12);
    wait_idle();

    // R12 start ignored during NCC
    send(6'd3, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    grab(f);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R12 start ignored in ncc", {state_code, cmd_oe}, {4'd14, 1'b0});
    repeat (7) @(negedge clk);
    chk("R12 idle after ignored start", {state_code, cmd_oe}, 5'b0);

    // R12/R5 hold states
    for (int m = 1; m < 4; m++) begin
      @(negedge clk); hold_mode = 2'(m);
      @(negedge clk); start = 1'b1;
      bad = 0;
      repeat (3) begin
        @(negedge clk);
        if (state_code != 4'd0 || cmd_oe) bad++;
      end
      chk("R5 hold reads idle, R12 start ignored", bad, 0);
      start = 1'b0; hold_mode = 2'd0;
      repeat (2) @(negedge clk);
      chk("R12 released hold", {state_code, cmd_oe}, 5'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule